// File: doc/BRIEF.md
# Tilemap Entry Address Generator

This block converts a scrolled background pixel position into the byte address, inside a 64 KB video memory, of the two-byte tilemap entry that covers that pixel. A renderer presents the plane base bits, the two 2-bit plane size codes and the scrolled pixel coordinates together with a one-cycle request strobe. One clock later the block returns the registered entry address with a valid strobe.

All sixteen combinations of size codes are decoded, including the ones that have no documented meaning. One horizontal code collapses the plane to a single row. One vertical code mirrors the row index through an AND mask. Every plane is clipped to an 8 KB window whose upper address bits are fixed by the base. The block does not fetch pattern data, read memory, apply priority or look up scroll tables.

Top module: `tmap_entry_addr`

## Requirements
- R1: While reset is asserted and after its release, before any request, `valid_o` is 0 and `addr_o` is 0.
- R2: `valid_o` is 1 on exactly the cycle after a cycle where `req_i` is 1, and 0 otherwise.
- R3: `addr_o[15:13]` equals `base_i` as sampled on the request cycle.
- R4: `addr_o[0]` is always 0, because each entry is two bytes.
- R5: The column is `px_i >> 3` wrapped to the column count. Horizontal code 00 gives 32 columns, 01 gives 64 columns and 11 gives 128 columns.
- R6: Horizontal code 10 gives 32 columns and exactly one row. The vertical coordinate and vertical code have no effect, so `addr_o[12:6]` is 0.
- R7: With horizontal code 00, vertical codes 00, 01 and 11 wrap the row (`py_i >> 3`) to 32, 64 and 128 rows.
- R8: With horizontal code 00 and vertical code 10, the row is `(py_i >> 3) mod 128` ANDed with 95. Rows therefore repeat as 0–31, 0–31, 64–95, 64–95.
- R9: With horizontal code 01, vertical codes 00 and 10 give 32 rows, and codes 01 and 11 give 64 rows.
- R10: With horizontal code 11, every vertical code gives 32 rows.
- R11: `addr_o[12:0]` equals `((row × columns + column) × 2) mod 8192`. Pixel bits 2:0 of either coordinate have no effect.
- R12: The inputs are sampled only on a request cycle. `addr_o` holds its value when `req_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; the other inputs are sampled when it is 1 |
| base_i | input | 3 | Plane base, placed in address bits 15:13 |
| hsize_i | input | 2 | Horizontal plane size code |
| vsize_i | input | 2 | Vertical plane size code |
| px_i | input | 10 | Scrolled horizontal pixel coordinate |
| py_i | input | 10 | Scrolled vertical pixel coordinate |
| addr_o | output | 16 | Registered byte address of the tilemap entry |
| valid_o | output | 1 | High for one cycle when `addr_o` is new |

## Verification
On every cycle, the assertions check the request-to-valid timing and the hold of the address between requests. They also check that the base bits pass through, that addresses are always even, and that the one-row code never produces a nonzero row offset. The bench scenarios are the only check of the row and column wrapping for each size code, of the mirrored row pattern of the masked vertical code, and of the clipping of oversized planes to the 8 KB window. The bench compares those against hand-computed vectors and against a reference model of rows and columns written in terms of row and column counts.

// File: rtl/tmap_addr_pkg.sv
package tmap_addr_pkg;
  // Tile index width: the widest plane has 128 rows or columns.
  localparam int unsigned IDX_W   = 7;
  // Pixels per tile edge, as a shift amount.
  localparam int unsigned TILE_SH = 3;
  // Bits needed for a row shift of 5, 6 or 7.
  localparam int unsigned SH_W    = 3;

  typedef struct packed {
    logic [IDX_W-1:0] col_mask;  // wraps the column index
    logic [SH_W-1:0]  row_sh;    // log2 of the column count
    logic [IDX_W-1:0] row_mask;  // wraps or mirrors the row index
  } plane_geom_t;
endpackage

// File: rtl/tmap_geom_decode.sv
module tmap_geom_decode
  import tmap_addr_pkg::*;
(
  input  logic [1:0]  hsize_i,
  input  logic [1:0]  vsize_i,
  output plane_geom_t geom_o
);
  // Column count from the horizontal code; code 10 falls back to 32.
  always_comb begin
    unique case (hsize_i)
      2'b01: begin
        geom_o.col_mask = IDX_W'(7'h3f);
        geom_o.row_sh   = SH_W'(6);
      end
      2'b11: begin
        geom_o.col_mask = IDX_W'(7'h7f);
        geom_o.row_sh   = SH_W'(7);
      end
      default: begin
        geom_o.col_mask = IDX_W'(7'h1f);
        geom_o.row_sh   = SH_W'(5);
      end
    endcase
    // The row mask carries the vertical code in its two top bits, so an
    // invalid code gives a mirrored row. Rows that do not fit are clipped
    // later by the 8 KB window. Horizontal code 10 forces a single row.
    if (hsize_i == 2'b10) geom_o.row_mask = '0;
    else                  geom_o.row_mask = {vsize_i, 5'h1f};
  end
endmodule

// File: rtl/tmap_tile_index.sv
module tmap_tile_index
  import tmap_addr_pkg::*;
#(
  parameter int unsigned PIX_W = 10
) (
  input  logic [PIX_W-1:0] px_i,
  input  logic [PIX_W-1:0] py_i,
  input  plane_geom_t      geom_i,
  output logic [IDX_W-1:0] col_o,
  output logic [IDX_W-1:0] row_o
);
  logic [IDX_W-1:0] col_raw;
  logic [IDX_W-1:0] row_raw;

  // The pixel coordinate becomes a tile index; a wider index wraps at 128.
  assign col_raw = IDX_W'(px_i >> TILE_SH);
  assign row_raw = IDX_W'(py_i >> TILE_SH);

  assign col_o = col_raw & geom_i.col_mask;
  assign row_o = row_raw & geom_i.row_mask;
endmodule

// File: rtl/tmap_offset_compose.sv
module tmap_offset_compose
  import tmap_addr_pkg::*;
#(
  parameter int unsigned WIN_W = 13
) (
  input  logic [IDX_W-1:0] col_i,
  input  logic [IDX_W-1:0] row_i,
  input  logic [SH_W-1:0]  row_sh_i,
  output logic [WIN_W-1:0] off_o
);
  // Entry index within the window; bit 0 of the byte offset is always 0.
  localparam int unsigned LIN_W = WIN_W - 1;

  logic [LIN_W-1:0] row_part;
  logic [LIN_W-1:0] lin;

  // Shifting at width LIN_W drops rows that fall outside the 8 KB window.
  assign row_part = LIN_W'(row_i) << row_sh_i;
  // The column is below the column count, so OR acts as an add.
  assign lin      = row_part | LIN_W'(col_i);
  assign off_o    = {lin, 1'b0};
endmodule

// File: rtl/tmap_entry_addr.sv
module tmap_entry_addr
  import tmap_addr_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic [ADDR_W-WIN_W-1:0] base_i,
  input  logic [1:0]              hsize_i,
  input  logic [1:0]              vsize_i,
  input  logic [PIX_W-1:0]        px_i,
  input  logic [PIX_W-1:0]        py_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic                    valid_o
);
  localparam int unsigned BASE_W = ADDR_W - WIN_W;

  plane_geom_t      geom;
  logic [IDX_W-1:0] col;
  logic [IDX_W-1:0] row;
  logic [WIN_W-1:0] off;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              valid_q, valid_d;

  tmap_geom_decode u_geom (
    .hsize_i (hsize_i),
    .vsize_i (vsize_i),
    .geom_o  (geom)
  );

  tmap_tile_index #(.PIX_W(PIX_W)) u_index (
    .px_i   (px_i),
    .py_i   (py_i),
    .geom_i (geom),
    .col_o  (col),
    .row_o  (row)
  );

  tmap_offset_compose #(.WIN_W(WIN_W)) u_off (
    .col_i    (col),
    .row_i    (row),
    .row_sh_i (geom.row_sh),
    .off_o    (off)
  );

  // Next state: load on request, otherwise hold the address.
  always_comb begin
    valid_d = req_i;
    addr_d  = addr_q;
    if (req_i) addr_d = {base_i, off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (req_i) addr_q <= addr_d;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o);
  assert_base_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (addr_o[ADDR_W-1:WIN_W] == $past(base_i)));
  assert_even_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !addr_o[0]);
  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(addr_o));
  assert_single_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && hsize_i == 2'b10) |=> (addr_o[WIN_W-1:6] == '0));

  if (BASE_W < 1) begin : g_bad_split
    initial assert_window_split_R3: assert (0) else $error("window wider than address");
  end
endmodule

// File: tb/tb_tmap_entry_addr.sv
module tb_tmap_entry_addr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [2:0]  base;
  logic [1:0]  hs, vs;
  logic [9:0]  px, py;
  logic [15:0] addr;
  logic        valid;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmap_entry_addr dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .base_i(base),
    .hsize_i(hs), .vsize_i(vs), .px_i(px), .py_i(py),
    .addr_o(addr), .valid_o(valid)
  );

  // Vector: {hsize, vsize, base, px, py, expected address}
  localparam logic [42:0] VEC [12] = '{
    {2'b00, 2'b00, 3'd0, 10'd0,    10'd0,    16'h0000},  // R1 origin, R11
    {2'b00, 2'b00, 3'd1, 10'd43,   10'd16,   16'h208A},  // R3, R11 low bits
    {2'b00, 2'b00, 3'd0, 10'd264,  10'd320,  16'h0202},  // R5, R7 wrap 32x32
    {2'b01, 2'b01, 3'd2, 10'd504,  10'd504,  16'h5FFE},  // R9 64x64 corner
    {2'b11, 2'b00, 3'd7, 10'd1016, 10'd248,  16'hFFFE},  // R10 128x32 corner
    {2'b10, 2'b11, 3'd0, 10'd320,  10'd800,  16'h0010},  // R6 one row
    {2'b00, 2'b10, 3'd0, 10'd0,    10'd320,  16'h0200},  // R8 row 40 -> 8
    {2'b00, 2'b10, 3'd0, 10'd8,    10'd800,  16'h1102},  // R8 row 100 -> 68
    {2'b00, 2'b11, 3'd0, 10'd248,  10'd1016, 16'h1FFE},  // R7 32x128 corner
    {2'b01, 2'b10, 3'd0, 10'd560,  10'd320,  16'h040C},  // R9 code 10 -> 32 rows
    {2'b11, 2'b11, 3'd0, 10'd24,   10'd400,  16'h1206},  // R10 row 50 -> 18
    {2'b01, 2'b00, 3'd3, 10'd519,  10'd264,  16'h6080}   // R5 col 64 -> 0
  };

  function automatic logic [15:0] ref_addr(input logic [1:0] h, input logic [1:0] v,
                                           input logic [2:0] b, input int x, input int y);
    int cols, rows, c, r, off;
    cols = (h == 2'b01) ? 64 : (h == 2'b11) ? 128 : 32;
    if (h == 2'b10) rows = 1;
    else if (h == 2'b00) rows = (v == 2'b00) ? 32 : (v == 2'b01) ? 64 : 128;
    else if (h == 2'b01) rows = v[0] ? 64 : 32;
    else rows = 32;
    c = (x / 8) % cols;
    r = (y / 8) % rows;
    if (h == 2'b00 && v == 2'b10) r = (r < 32) ? r : (r < 64) ? r - 32 :
                                       (r < 96) ? r : r - 32;
    off = ((r * cols + c) * 2) % 8192;
    return {b, 13'(off)};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] h, input logic [1:0] v, input logic [2:0] b,
                       input logic [9:0] x, input logic [9:0] y);
    @(negedge clk);
    hs = h; vs = v; base = b; px = x; py = y; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; base = '0; hs = '0; vs = '0; px = '0; py = '0;
    #(CLK_PERIOD * 3 + 2);
    check("R1 addr in reset", addr, 16'h0000);
    check("R1 valid in reset", {15'd0, valid}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid after reset", {15'd0, valid}, 16'd0);
    check("R1 addr after reset", addr, 16'h0000);

    // Vector table
    for (int i = 0; i < 12; i++) begin
      issue(VEC[i][42:41], VEC[i][40:39], VEC[i][38:36], VEC[i][35:26], VEC[i][25:16]);
      check("R2 valid one cycle after request", {15'd0, valid}, 16'd1);
      check("R5-R11 vector address", addr, VEC[i][15:0]);
    end

    // R2: valid drops with no request
    @(negedge clk);
    check("R2 valid low without request", {15'd0, valid}, 16'd0);

    // R12: inputs changed without a request do not reach the output
    issue(2'b01, 2'b01, 3'd5, 10'd100, 10'd200);
    begin
      logic [15:0] held;
      held = addr;
      check("R12 captured", held, ref_addr(2'b01, 2'b01, 3'd5, 100, 200));
      hs = 2'b11; vs = 2'b10; base = 3'd2; px = 10'd999; py = 10'd777;
      @(negedge clk);
      @(negedge clk);
      check("R12 hold without request", addr, held);
    end

    // R11: pixel bits 2:0 ignored
    issue(2'b00, 2'b01, 3'd4, 10'd81, 10'd93);
    check("R11 low pixel bits", addr, ref_addr(2'b00, 2'b01, 3'd4, 80, 88));

    // R6: vertical input has no effect under horizontal code 10
    issue(2'b10, 2'b01, 3'd1, 10'd40, 10'd1000);
    check("R6 one-row plane", addr, 16'h200A);

    // R8: all four row quarters of the mirrored plane
    for (int q = 0; q < 4; q++) begin
      issue(2'b00, 2'b10, 3'd0, 10'd0, 10'(q * 256 + 8));
      check("R8 mirrored quarter", addr, 16'((q >= 2 ? 64 * 64 : 0) + 64));
    end

    // Sweep all size codes against the reference model (R5, R7, R9, R10, R11, R3)
    for (int h = 0; h < 4; h++)
      for (int v = 0; v < 4; v++)
        for (int k = 0; k < 8; k++) begin
          int x, y;
          x = (k * 137 + h * 29 + 5) % 1024;
          y = (k * 211 + v * 53 + 900 * (k % 2)) % 1024;
          issue(2'(h), 2'(v), 3'(k), 10'(x), 10'(y));
          check("R3-R11 sweep", addr, ref_addr(2'(h), 2'(v), 3'(k), x, y));
        end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule